// File: doc/BRIEF.md
# Hit Time Offset-Shift Formatter

This block turns a stream of raw hit measurements into packed 16-bit output words. Each incoming beat may carry one hit, made of a 16-bit raw time, a 5-bit channel number and an edge flag, and may mark the end of an event. For every hit the block subtracts a programmable offset from the raw time and saturates at zero. It then shifts the difference right by a programmable amount to coarsen the resolution, and packs the low bits of the result with the channel and the edge flag. Only the upper twelve bits of the offset take part in the subtraction.

Each event opens with a header word that carries a user ID code. A configuration bit can suppress the header of an event that contains no hits. Only the header goes, so every module sharing a trigger still sees the same sequence of events. When a beat needs both a header and a data word, the block lowers `in_ready` for one cycle. Words leave through a small internal queue at one word per cycle, and the output shows no valid word while the queue is empty.

Top module: `hfmt_top`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: A data word has bit 15 = 0, the channel in bits 14:10, the edge flag in bit 9, and in bits 8:0 the low nine bits of (raw time minus effective offset) shifted right by `cfg_shift` (0 to 15).
- R3: The effective offset is `cfg_offset` with bits 3:0 forced to zero, so those four bits have no effect on any word.
- R4: When the raw time is below the effective offset, the time field of the data word is 0.
- R5: A header word has bit 15 = 1, bits 14:8 = 0 and the ID code in bits 7:0. It is the first word of every event that has hits, and all words leave in the order their beats were accepted.
- R6: With `cfg_skip_empty_hdr` = 0, an event with no hits (a beat with `in_hit` = 0 and `in_last` = 1 as its only beat) produces exactly one header word.
- R7: With `cfg_skip_empty_hdr` = 1, an event with no hits produces no word at all, and events with hits still get their header.
- R8: A beat that needs a header and a data word is followed by one cycle with `in_ready` = 0, and no word is lost. An end marker without a hit, arriving after hits, adds no word.
- R9: `out_valid` is 0 whenever no word is queued, and at most one word leaves per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_offset | input | 16 | Offset subtracted from raw times (bits 3:0 ignored) |
| cfg_shift | input | 4 | Right shift applied after subtraction |
| cfg_id | input | 8 | ID code placed in header words |
| cfg_skip_empty_hdr | input | 1 | 1 = omit the header of events with no hits |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts a beat this cycle |
| in_hit | input | 1 | Beat carries a hit |
| in_last | input | 1 | Beat ends the current event |
| in_chan | input | 5 | Channel number of the hit |
| in_rise | input | 1 | Edge flag of the hit |
| in_time | input | 16 | Raw hit time |
| out_valid | output | 1 | Output word present |
| out_word | output | 16 | Header or data word |

## Verification
If the event-state flag were wrong, a header would go missing or appear twice. The scoreboard sees this on the very next output word, two cycles after the beat is accepted. A fault in the offset mask or the saturation shows up in the time field of the first affected data word. A fault in the split-beat hold shows up as a dropped or duplicated data word, or as `in_ready` staying high in the cycle after a beat that opens an event with a hit. Queue pointer faults surface as out-of-order words or as `out_valid` high once traffic has drained.

// File: rtl/hfmt_pkg.sv
package hfmt_pkg;
  localparam int unsigned HF_TIME_W   = 16;
  localparam int unsigned HF_CHAN_W   = 5;
  localparam int unsigned HF_TFIELD_W = 9;
  localparam int unsigned HF_ID_W     = 8;
  localparam int unsigned HF_SHIFT_W  = 4;
  localparam int unsigned HF_OFF_LSB  = 4;
  localparam int unsigned HF_DEPTH    = 8;

  typedef enum logic {
    EV_IDLE = 1'b0,
    EV_OPEN = 1'b1
  } ev_state_e;
endpackage

// File: rtl/hfmt_calc.sv
module hfmt_calc #(
  parameter int unsigned TIME_W   = hfmt_pkg::HF_TIME_W,
  parameter int unsigned CHAN_W   = hfmt_pkg::HF_CHAN_W,
  parameter int unsigned TFIELD_W = hfmt_pkg::HF_TFIELD_W,
  parameter int unsigned SHIFT_W  = hfmt_pkg::HF_SHIFT_W,
  parameter int unsigned OFF_LSB  = hfmt_pkg::HF_OFF_LSB,
  localparam int unsigned WORD_W  = 2 + CHAN_W + TFIELD_W
) (
  input  logic [TIME_W-1:0]  raw_time,
  input  logic [CHAN_W-1:0]  chan,
  input  logic               rise,
  input  logic [TIME_W-1:0]  offset,
  input  logic [SHIFT_W-1:0] shift,
  output logic [WORD_W-1:0]  word
);
  logic [TIME_W-1:0] off_eff;
  logic [TIME_W-1:0] diff;
  logic [TIME_W-1:0] coarse;

  generate
    if (OFF_LSB == 0) begin : g_full_off
      assign off_eff = offset;
    end else begin : g_masked_off
      assign off_eff = {offset[TIME_W-1:OFF_LSB], {OFF_LSB{1'b0}}};
    end
  endgenerate

  always_comb begin
    if (raw_time >= off_eff) diff = raw_time - off_eff;
    else                     diff = '0;
    coarse = diff >> shift;
    word   = {1'b0, chan, rise, coarse[TFIELD_W-1:0]};
  end

  // R4: a time below the offset never yields a nonzero time field
  always_comb begin
    if (raw_time < off_eff)
      a_r4_sat_zero: assert (word[TFIELD_W-1:0] == '0);
  end
endmodule

// File: rtl/hfmt_ctl.sv
module hfmt_ctl #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ID_W   = hfmt_pkg::HF_ID_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_hit,
  input  logic              in_last,
  output logic              in_ready,
  input  logic [WORD_W-1:0] data_word,
  input  logic [ID_W-1:0]   cfg_id,
  input  logic              cfg_skip,
  input  logic              room,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_data
);
  import hfmt_pkg::*;

  localparam int unsigned PAD_W = WORD_W - 1 - ID_W;

  ev_state_e         state_q;
  logic              pend_q;
  logic [WORD_W-1:0] pend_word_q;
  logic              accept;
  logic              opening;
  logic [WORD_W-1:0] hdr_word;

  assign in_ready = !pend_q && room;
  assign accept   = in_valid && in_ready;
  assign opening  = (state_q == EV_IDLE);
  assign hdr_word = {1'b1, {PAD_W{1'b0}}, cfg_id};

  always_comb begin
    wr_en   = 1'b0;
    wr_data = data_word;
    if (pend_q) begin
      wr_en   = 1'b1;
      wr_data = pend_word_q;
    end else if (accept) begin
      if (in_hit) begin
        wr_en   = 1'b1;
        wr_data = opening ? hdr_word : data_word;
      end else if (in_last && opening && !cfg_skip) begin
        wr_en   = 1'b1;
        wr_data = hdr_word;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= EV_IDLE;
      pend_q      <= 1'b0;
      pend_word_q <= '0;
    end else begin
      if (pend_q) pend_q <= 1'b0;
      if (accept) begin
        if (in_hit && opening) begin
          pend_q      <= 1'b1;
          pend_word_q <= data_word;
        end
        if (in_last)     state_q <= EV_IDLE;
        else if (in_hit) state_q <= EV_OPEN;
      end
    end
  end

  // R5: the first hit of an event writes a header before its data
  a_r5_hdr_first: assert property (@(posedge clk) disable iff (rst)
    (accept && in_hit && opening) |-> (wr_en && wr_data[WORD_W-1]));

  // R8: a split beat holds the input for one cycle and writes the data word
  a_r8_split_hold: assert property (@(posedge clk) disable iff (rst)
    (accept && in_hit && opening) |=> (!in_ready && wr_en && !wr_data[WORD_W-1]));

  // R6: an empty event gives a header when suppression is off
  a_r6_empty_hdr: assert property (@(posedge clk) disable iff (rst)
    (accept && !in_hit && in_last && opening && !cfg_skip) |-> (wr_en && wr_data[WORD_W-1]));

  // R7: an empty event writes nothing when suppression is on
  a_r7_empty_skip: assert property (@(posedge clk) disable iff (rst)
    (accept && !in_hit && in_last && opening && cfg_skip) |-> !wr_en);
endmodule

// File: rtl/hfmt_fifo.sv
module hfmt_fifo #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DEPTH  = hfmt_pkg::HF_DEPTH,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              room,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr;
  logic [AW-1:0]     rd_ptr;
  logic [CW-1:0]     count;
  logic              rd_en;

  assign rd_en = (count != '0);
  assign room  = (count <= CW'(DEPTH - 2));

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) out_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= rd_en;
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= rd_ptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R9: the queue never takes a word it has no space for
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (count < CW'(DEPTH)));
endmodule

// File: rtl/hfmt_top.sv
module hfmt_top #(
  parameter int unsigned TIME_W   = hfmt_pkg::HF_TIME_W,
  parameter int unsigned CHAN_W   = hfmt_pkg::HF_CHAN_W,
  parameter int unsigned TFIELD_W = hfmt_pkg::HF_TFIELD_W,
  parameter int unsigned ID_W     = hfmt_pkg::HF_ID_W,
  parameter int unsigned SHIFT_W  = hfmt_pkg::HF_SHIFT_W,
  parameter int unsigned OFF_LSB  = hfmt_pkg::HF_OFF_LSB,
  parameter int unsigned DEPTH    = hfmt_pkg::HF_DEPTH,
  localparam int unsigned WORD_W  = 2 + CHAN_W + TFIELD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TIME_W-1:0]  cfg_offset,
  input  logic [SHIFT_W-1:0] cfg_shift,
  input  logic [ID_W-1:0]    cfg_id,
  input  logic               cfg_skip_empty_hdr,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_hit,
  input  logic               in_last,
  input  logic [CHAN_W-1:0]  in_chan,
  input  logic               in_rise,
  input  logic [TIME_W-1:0]  in_time,
  output logic               out_valid,
  output logic [WORD_W-1:0]  out_word
);
  logic [WORD_W-1:0] data_word;
  logic [WORD_W-1:0] wr_data;
  logic              wr_en;
  logic              room;

  hfmt_calc #(
    .TIME_W(TIME_W), .CHAN_W(CHAN_W), .TFIELD_W(TFIELD_W),
    .SHIFT_W(SHIFT_W), .OFF_LSB(OFF_LSB)
  ) calc_i (
    .raw_time(in_time), .chan(in_chan), .rise(in_rise),
    .offset(cfg_offset), .shift(cfg_shift), .word(data_word)
  );

  hfmt_ctl #(.WORD_W(WORD_W), .ID_W(ID_W)) ctl_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_hit(in_hit),
    .in_last(in_last), .in_ready(in_ready), .data_word(data_word),
    .cfg_id(cfg_id), .cfg_skip(cfg_skip_empty_hdr), .room(room),
    .wr_en(wr_en), .wr_data(wr_data)
  );

  hfmt_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .room(room), .out_valid(out_valid), .out_data(out_word)
  );
endmodule

// File: tb/hfmt_top_tb_top.sv
module hfmt_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cfg_offset = '0;
  logic [3:0]  cfg_shift = '0;
  logic [7:0]  cfg_id = '0;
  logic        cfg_skip_empty_hdr = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_hit = 1'b0;
  logic        in_last = 1'b0;
  logic [4:0]  in_chan = '0;
  logic        in_rise = 1'b0;
  logic [15:0] in_time = '0;
  logic        out_valid;
  logic [15:0] out_word;

  int tests = 0;
  int fails = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  bit          ev_open = 1'b0;
  bit          done = 1'b0;
  int unsigned lcg = 32'h1234_5678;

  always #2.5 clk = ~clk;

  hfmt_top dut_i (
    .clk(clk), .rst(rst), .cfg_offset(cfg_offset), .cfg_shift(cfg_shift),
    .cfg_id(cfg_id), .cfg_skip_empty_hdr(cfg_skip_empty_hdr),
    .in_valid(in_valid), .in_ready(in_ready), .in_hit(in_hit),
    .in_last(in_last), .in_chan(in_chan), .in_rise(in_rise),
    .in_time(in_time), .out_valid(out_valid), .out_word(out_word)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_data(input logic [4:0] c, input logic r, input logic [15:0] t);
    int off, d;
    off = {cfg_offset[15:4], 4'h0};
    d = (int'(t) >= off) ? (int'(t) - off) : 0;
    d = d >> cfg_shift;
    return {1'b0, c, r, d[8:0]};
  endfunction

  function automatic logic [15:0] exp_hdr();
    return {1'b1, 7'h00, cfg_id};
  endfunction

  // driver: called at a negedge, leaves at the negedge after acceptance
  task automatic beat(input bit hit, input bit last, input logic [4:0] c,
                      input logic r, input logic [15:0] t, input string tag);
    bit split;
    while (!in_ready) begin
      in_valid = 1'b0;
      @(negedge clk);
    end
    in_valid = 1'b1; in_hit = hit; in_last = last;
    in_chan = c; in_rise = r; in_time = t;
    split = 1'b0;
    if (hit) begin
      if (!ev_open) begin
        exp_q.push_back(exp_hdr()); tag_q.push_back("R5");
        split = 1'b1;
      end
      exp_q.push_back(exp_data(c, r, t)); tag_q.push_back(tag);
    end else if (last && !ev_open && !cfg_skip_empty_hdr) begin
      exp_q.push_back(exp_hdr()); tag_q.push_back("R6");
    end
    if (last) ev_open = 1'b0;
    else if (hit) ev_open = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (split) check("R8 ready low after split", {15'd0, in_ready}, 16'd0);
  endtask

  task automatic drain();
    repeat (8) @(negedge clk);
    check("R5 queue empty after drain", 16'(exp_q.size()), 16'd0);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R9 unexpected word actual=%h expected=none", out_word);
      end else begin
        logic [15:0] e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(tg, out_word, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid after reset", {15'd0, out_valid}, 16'd0);
    check("R1 in_ready after reset", {15'd0, in_ready}, 16'd1);

    // R2: plain event, no offset, no shift
    cfg_id = 8'h5A;
    beat(1, 0, 5'd3, 1'b1, 16'h0123, "R2");
    beat(1, 0, 5'd17, 1'b0, 16'h01FF, "R2");
    beat(1, 1, 5'd31, 1'b1, 16'h0042, "R2");
    drain();

    // R3 / R4: masked offset, saturation, shift 2
    cfg_offset = 16'h123F; cfg_shift = 4'd2; cfg_id = 8'hC3;
    beat(1, 0, 5'd1, 1'b0, 16'h1235, "R3");
    beat(1, 0, 5'd2, 1'b1, 16'h1230, "R3");
    beat(1, 0, 5'd4, 1'b0, 16'h1000, "R4");
    beat(1, 0, 5'd5, 1'b0, 16'h122F, "R4");
    beat(1, 1, 5'd6, 1'b1, 16'hFFFF, "R2");
    drain();

    // R6: empty event with headers on
    cfg_skip_empty_hdr = 1'b0; cfg_id = 8'h11;
    beat(0, 1, 5'd0, 1'b0, 16'h0, "R6");
    drain();

    // R7: empty event suppressed, then an event with hits keeps its header
    cfg_skip_empty_hdr = 1'b1; cfg_id = 8'h22;
    beat(0, 1, 5'd0, 1'b0, 16'h0, "R7");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R7 no word for skipped empty event", {15'd0, out_valid}, 16'd0);
    end
    beat(1, 1, 5'd9, 1'b1, 16'h0077, "R7");
    drain();

    // R8: end marker without hit after hits, back-to-back events
    cfg_offset = 16'h0000; cfg_shift = 4'd0;
    beat(1, 0, 5'd7, 1'b0, 16'h0010, "R8");
    beat(1, 0, 5'd8, 1'b0, 16'h0011, "R8");
    beat(0, 1, 5'd0, 1'b0, 16'h0, "R8");
    beat(1, 1, 5'd10, 1'b1, 16'h0012, "R8");
    beat(1, 1, 5'd11, 1'b0, 16'h0013, "R8");
    drain();

    // R2: maximum shift
    cfg_shift = 4'd15;
    beat(1, 1, 5'd12, 1'b1, 16'hFFFF, "R2");
    beat(1, 1, 5'd13, 1'b1, 16'h7FFF, "R2");
    drain();

    // mixed traffic from a deterministic generator
    for (int ev = 0; ev < 60; ev++) begin
      int nh;
      lcg = lcg * 1103515245 + 12345;
      nh = (lcg >> 16) % 5;
      cfg_skip_empty_hdr = lcg[3];
      cfg_shift = 4'((lcg >> 8) % 6);
      cfg_offset = 16'(lcg >> 12);
      cfg_id = 8'(ev);
      if (nh == 0) begin
        beat(0, 1, 5'd0, 1'b0, 16'h0, cfg_skip_empty_hdr ? "R7" : "R6");
      end else begin
        for (int h = 0; h < nh; h++) begin
          lcg = lcg * 1103515245 + 12345;
          beat(1, (h == nh - 1), 5'(lcg >> 3), lcg[20], 16'(lcg >> 9), "R2");
        end
      end
    end
    drain();

    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R9 idle output", {15'd0, out_valid}, 16'd0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule